// File: doc/BRIEF.md
# Lane-Column Vector Pre-add Multiply-Accumulator

This block is a fixed-point vector datapath. It keeps a bank of signed accumulators, one for each output lane. Each operation presents three operand vectors: X, Y and Z. Each operation also presents one selection index per lane and per column for each vector. For every lane and column, the block picks one X element, one Y element and one Z element. It can sum X and Y first (pre-add), and it multiplies the result by the Z element. The products of all columns are summed, and that sum is added to the lane's accumulator. A clear flag loads the sum into the accumulator instead of adding it.

The work is split over three pipeline stages: operand pick/pre-add, multiply, and reduce/accumulate. A valid bit travels with the data through the stages. The accumulators are visible on a wide readout bus. A one-cycle strobe marks each cycle in which the accumulators were updated.

The operation input uses a valid/ready handshake. The pipeline never stalls, so `op_ready` is always high and the block applies no back-pressure. Every cycle in which `op_valid` is high is an accepted operation, and back-to-back operations are allowed.

Top module: `vec_lanemac`

## Requirements
- R1: During and after reset, every accumulator reads zero and `acc_strobe` is low until the first accepted operation completes.
- R2: `op_ready` is always 1, so every cycle with `op_valid` high is accepted, with no back-pressure.
- R3: An operation accepted at rising edge E updates the accumulators at edge E+2. `acc_strobe` is high in exactly the cycle after each such update, and it is low otherwise.
- R4: With `op_preadd`=1, each lane adds the sum over columns of Zsel*(Xsel+Ysel). The pre-add is exact in 17 bits and the products are signed.
- R5: With `op_preadd`=0, each product is Zsel*Xsel, and the Y vector and Y indices have no effect on the result.
- R6: Element e of a vector occupies bits [e*16 +: 16]. The index for lane l and column c occupies bits [(l*4+c)*4 +: 4] of its index bus. Lane l's accumulator occupies `acc_data` bits [l*48 +: 48].
- R7: An index value of 8 or more selects the value zero for that operand.
- R8: With `op_clear`=0, the lane sum is added to the previous accumulator value. Accumulators hold when no operation completes.
- R9: With `op_clear`=1, each accumulator is loaded with the new lane sum, and its old value is discarded.
- R10: Accumulator arithmetic wraps modulo 2^48 in two's complement, with no saturation.
- R11: Back-to-back operations accumulate correctly, with each one building on the result of the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation accepted (always 1) |
| op_x | input | 128 | X vector, 8 signed 16-bit elements |
| op_y | input | 128 | Y vector, 8 signed 16-bit elements |
| op_z | input | 128 | Z vector, 8 signed 16-bit elements |
| op_xidx | input | 64 | X index per lane/column, 4 bits each |
| op_yidx | input | 64 | Y index per lane/column, 4 bits each |
| op_zidx | input | 64 | Z index per lane/column, 4 bits each |
| op_preadd | input | 1 | 1: multiply Z by X+Y; 0: multiply Z by X |
| op_clear | input | 1 | 1: load the accumulators instead of adding to them |
| acc_strobe | output | 1 | Accumulators were updated at the last edge |
| acc_data | output | 192 | Four 48-bit signed accumulators |

## Verification
Any wrong pick, pre-add, product or accumulator value shows up on `acc_data` three edges after the operation is accepted. Because the accumulators carry the error forward, it also stays on the bus for every later cycle until a clear. A fault in the valid chain shows up as a misplaced `acc_strobe` in the same cycle. The bench compares both outputs against a behavioural model on every cycle. That includes idle cycles, where any drift of a held accumulator is caught at once.

// File: rtl/vlm_pkg.sv
package vlm_pkg;
  localparam int unsigned VLM_LANES = 4;
  localparam int unsigned VLM_COLS  = 4;
  localparam int unsigned VLM_ELEMS = 8;
  localparam int unsigned VLM_DW    = 16;
  localparam int unsigned VLM_IDXW  = 4;
  localparam int unsigned VLM_AW    = 48;

  // control flags that travel with an operation into the first stage
  typedef struct packed {
    logic preadd;
    logic clear;
  } vlm_ctrl_t;
endpackage

// File: rtl/vlm_select.sv
module vlm_select
  import vlm_pkg::*;
#(
  parameter int unsigned LANES = VLM_LANES,
  parameter int unsigned COLS  = VLM_COLS,
  parameter int unsigned ELEMS = VLM_ELEMS,
  parameter int unsigned DW    = VLM_DW,
  parameter int unsigned IDXW  = VLM_IDXW,
  localparam int unsigned LN   = LANES * COLS,
  localparam int unsigned PW   = DW + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  vlm_ctrl_t                   in_ctrl,
  input  logic [ELEMS*DW-1:0]         in_x,
  input  logic [ELEMS*DW-1:0]         in_y,
  input  logic [ELEMS*DW-1:0]         in_z,
  input  logic [LN*IDXW-1:0]          in_xidx,
  input  logic [LN*IDXW-1:0]          in_yidx,
  input  logic [LN*IDXW-1:0]          in_zidx,
  output logic                        s1_valid,
  output logic                        s1_clear,
  output logic signed [PW-1:0]        s1_a [LN],
  output logic signed [DW-1:0]        s1_z [LN]
);
  localparam logic [IDXW:0] ELEMS_L = (IDXW+1)'(ELEMS);

  // index beyond the vector yields zero
  function automatic logic signed [DW-1:0] pick(
    input logic [ELEMS*DW-1:0] vec,
    input logic [IDXW-1:0]     idx
  );
    logic signed [DW-1:0] r;
    r = '0;
    for (int e = 0; e < ELEMS; e++) begin
      if (idx == IDXW'(e)) r = vec[e*DW +: DW];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_clear <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_clear <= in_ctrl.clear;
    end
  end

  for (genvar k = 0; k < LN; k++) begin : g_pair
    logic signed [DW-1:0] xe, ye, ze;
    logic signed [PW-1:0] a_d, a_q;
    logic signed [DW-1:0] z_q;

    always_comb begin
      xe  = pick(in_x, in_xidx[k*IDXW +: IDXW]);
      ye  = pick(in_y, in_yidx[k*IDXW +: IDXW]);
      ze  = pick(in_z, in_zidx[k*IDXW +: IDXW]);
      a_d = PW'(xe);
      if (in_ctrl.preadd) a_d = PW'(xe) + PW'(ye);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q <= '0;
        z_q <= '0;
      end else if (in_valid) begin
        a_q <= a_d;
        z_q <= ze;
      end
    end

    assign s1_a[k] = a_q;
    assign s1_z[k] = z_q;
  end

  AST_IDX_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ({1'b0, in_xidx[IDXW-1:0]} >= ELEMS_L) && ({1'b0, in_yidx[IDXW-1:0]} >= ELEMS_L)
    |=> s1_a[0] == '0); // R7

  AST_NO_PREADD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ctrl.preadd |=> s1_a[0][PW-1] == s1_a[0][PW-2]); // R5
endmodule

// File: rtl/vlm_mult.sv
module vlm_mult
  import vlm_pkg::*;
#(
  parameter int unsigned LANES = VLM_LANES,
  parameter int unsigned COLS  = VLM_COLS,
  parameter int unsigned DW    = VLM_DW,
  localparam int unsigned LN   = LANES * COLS,
  localparam int unsigned PW   = DW + 1,
  localparam int unsigned MW   = PW + DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_valid,
  input  logic                 s1_clear,
  input  logic signed [PW-1:0] s1_a [LN],
  input  logic signed [DW-1:0] s1_z [LN],
  output logic                 s2_valid,
  output logic                 s2_clear,
  output logic signed [MW-1:0] s2_p [LN]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_clear <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) s2_clear <= s1_clear;
    end
  end

  for (genvar k = 0; k < LN; k++) begin : g_mul
    logic signed [MW-1:0] ax, zx, p_d, p_q;
    always_comb begin
      ax  = MW'(s1_a[k]);
      zx  = MW'(s1_z[k]);
      p_d = ax * zx;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)        p_q <= '0;
      else if (s1_valid) p_q <= p_d;
    end
    assign s2_p[k] = p_q;
  end
endmodule

// File: rtl/vlm_accum.sv
module vlm_accum
  import vlm_pkg::*;
#(
  parameter int unsigned LANES = VLM_LANES,
  parameter int unsigned COLS  = VLM_COLS,
  parameter int unsigned DW    = VLM_DW,
  parameter int unsigned AW    = VLM_AW,
  localparam int unsigned LN   = LANES * COLS,
  localparam int unsigned MW   = 2 * DW + 1,
  localparam int unsigned SW   = MW + $clog2(COLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s2_valid,
  input  logic                 s2_clear,
  input  logic signed [MW-1:0] s2_p [LN],
  output logic                 acc_strobe,
  output logic [LANES*AW-1:0]  acc_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) acc_strobe <= 1'b0;
    else        acc_strobe <= s2_valid;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [SW-1:0] sum;
    logic signed [AW-1:0] sum_x, acc_q;

    always_comb begin
      sum = '0;
      for (int c = 0; c < COLS; c++) begin
        sum = sum + SW'(s2_p[l*COLS + c]);
      end
      sum_x = AW'(sum);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        acc_q <= '0;
      else if (s2_valid) acc_q <= s2_clear ? sum_x : acc_q + sum_x;
    end

    assign acc_data[l*AW +: AW] = acc_q;
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> $stable(acc_data)); // R8

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> acc_strobe); // R3
endmodule

// File: rtl/vec_lanemac.sv
module vec_lanemac
  import vlm_pkg::*;
#(
  parameter int unsigned LANES = VLM_LANES,
  parameter int unsigned COLS  = VLM_COLS,
  parameter int unsigned ELEMS = VLM_ELEMS,
  parameter int unsigned DW    = VLM_DW,
  parameter int unsigned IDXW  = VLM_IDXW,
  parameter int unsigned AW    = VLM_AW,
  localparam int unsigned LN   = LANES * COLS,
  localparam int unsigned PW   = DW + 1,
  localparam int unsigned MW   = PW + DW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  output logic                  op_ready,
  input  logic [ELEMS*DW-1:0]   op_x,
  input  logic [ELEMS*DW-1:0]   op_y,
  input  logic [ELEMS*DW-1:0]   op_z,
  input  logic [LN*IDXW-1:0]    op_xidx,
  input  logic [LN*IDXW-1:0]    op_yidx,
  input  logic [LN*IDXW-1:0]    op_zidx,
  input  logic                  op_preadd,
  input  logic                  op_clear,
  output logic                  acc_strobe,
  output logic [LANES*AW-1:0]   acc_data
);
  vlm_ctrl_t            ctrl;
  logic                 s1_valid, s1_clear, s2_valid, s2_clear;
  logic signed [PW-1:0] s1_a [LN];
  logic signed [DW-1:0] s1_z [LN];
  logic signed [MW-1:0] s2_p [LN];

  assign op_ready    = 1'b1;
  assign ctrl.preadd = op_preadd;
  assign ctrl.clear  = op_clear;

  vlm_select #(.LANES(LANES), .COLS(COLS), .ELEMS(ELEMS), .DW(DW), .IDXW(IDXW)) i_select (
    .clk(clk), .rst_n(rst_n), .in_valid(op_valid), .in_ctrl(ctrl),
    .in_x(op_x), .in_y(op_y), .in_z(op_z),
    .in_xidx(op_xidx), .in_yidx(op_yidx), .in_zidx(op_zidx),
    .s1_valid(s1_valid), .s1_clear(s1_clear), .s1_a(s1_a), .s1_z(s1_z)
  );

  vlm_mult #(.LANES(LANES), .COLS(COLS), .DW(DW)) i_mult (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_clear(s1_clear),
    .s1_a(s1_a), .s1_z(s1_z),
    .s2_valid(s2_valid), .s2_clear(s2_clear), .s2_p(s2_p)
  );

  vlm_accum #(.LANES(LANES), .COLS(COLS), .DW(DW), .AW(AW)) i_accum (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_clear(s2_clear), .s2_p(s2_p),
    .acc_strobe(acc_strobe), .acc_data(acc_data)
  );

  AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe == $past(op_valid, 3)); // R3

  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> op_ready); // R2
endmodule

// File: tb/test_vec_lanemac.sv
module test_vec_lanemac;
  localparam int CLK_NS = 10;
  localparam int L = 4, C = 4, E = 8, DW = 16, IW = 4, AW = 48;
  localparam int N = L * C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_preadd = 1'b0, op_clear = 1'b0;
  logic op_ready, acc_strobe;
  logic [E*DW-1:0] op_x = '0, op_y = '0, op_z = '0;
  logic [N*IW-1:0] op_xidx = '0, op_yidx = '0, op_zidx = '0;
  logic [L*AW-1:0] acc_data;

  vec_lanemac i_vec_lanemac (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_x(op_x), .op_y(op_y), .op_z(op_z),
    .op_xidx(op_xidx), .op_yidx(op_yidx), .op_zidx(op_zidx),
    .op_preadd(op_preadd), .op_clear(op_clear),
    .acc_strobe(acc_strobe), .acc_data(acc_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  string phase = "R1";

  // model state: pending updates keyed by the cycle they land
  int              q_due[$];
  bit              q_clr[$];
  logic [L*AW-1:0] q_sum[$];
  logic [AW-1:0]   exp_acc [L];

  // working operand set
  logic [E*DW-1:0] bx, by, bz;
  logic [N*IW-1:0] bxi, byi, bzi;

  function automatic longint el(logic [E*DW-1:0] v, logic [IW-1:0] idx);
    if (int'(idx) >= E) return 0;
    return longint'($signed(v[int'(idx)*DW +: DW]));
  endfunction

  task automatic chk(string tag, logic [L*AW-1:0] act, logic [L*AW-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, expv);
    end
  endtask

  task automatic compare();
    logic ev;
    logic [L*AW-1:0] ef;
    ev = 1'b0;
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      logic [L*AW-1:0] s;
      bit cl;
      s = q_sum.pop_front(); cl = q_clr.pop_front(); void'(q_due.pop_front());
      for (int l = 0; l < L; l++)
        exp_acc[l] = cl ? s[l*AW +: AW] : exp_acc[l] + s[l*AW +: AW];
      ev = 1'b1;
    end
    for (int l = 0; l < L; l++) ef[l*AW +: AW] = exp_acc[l];
    chk("R3 strobe", {{(L*AW-1){1'b0}}, acc_strobe}, {{(L*AW-1){1'b0}}, ev});
    chk("R2 ready", {{(L*AW-1){1'b0}}, op_ready}, {{(L*AW-1){1'b0}}, 1'b1});
    chk(phase, acc_data, ef);
  endtask

  // one cycle: check outputs, then drive the next input
  task automatic step(bit v, bit pre, bit clr);
    @(negedge clk);
    compare();
    op_valid = v;
    if (v) begin
      logic [L*AW-1:0] s;
      for (int l = 0; l < L; l++) begin
        longint acc_l;
        acc_l = 0;
        for (int c = 0; c < C; c++) begin
          int k;
          longint a;
          k = l*C + c;
          a = el(bx, bxi[k*IW +: IW]);
          if (pre) a = a + el(by, byi[k*IW +: IW]);
          acc_l = acc_l + a * el(bz, bzi[k*IW +: IW]);
        end
        s[l*AW +: AW] = AW'(acc_l);
      end
      q_due.push_back(cyc + 3); q_clr.push_back(clr); q_sum.push_back(s);
      op_x = bx; op_y = by; op_z = bz;
      op_xidx = bxi; op_yidx = byi; op_zidx = bzi;
      op_preadd = pre; op_clear = clr;
    end else begin
      op_x = $urandom; op_preadd = $urandom; op_clear = $urandom;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic rand_ops(bit in_range);
    for (int e = 0; e < E; e++) begin
      bx[e*DW +: DW] = DW'($urandom); by[e*DW +: DW] = DW'($urandom); bz[e*DW +: DW] = DW'($urandom);
    end
    for (int k = 0; k < N; k++) begin
      bxi[k*IW +: IW] = IW'($urandom_range(in_range ? E-1 : 15, 0));
      byi[k*IW +: IW] = IW'($urandom_range(in_range ? E-1 : 15, 0));
      bzi[k*IW +: IW] = IW'($urandom_range(in_range ? E-1 : 15, 0));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 190000);
    n_fail++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    summary();
  end

  initial begin
    for (int l = 0; l < L; l++) exp_acc[l] = '0;
    // R1: reset state
    phase = "R1";
    for (int i = 0; i < 4; i++) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    idle(2);

    // R4: pre-add, identity index per column, known values, loaded with clear
    phase = "R4";
    for (int e = 0; e < E; e++) begin
      bx[e*DW +: DW] = DW'(e + 1); by[e*DW +: DW] = DW'(-10 * e); bz[e*DW +: DW] = DW'(3 - e);
    end
    for (int k = 0; k < N; k++) begin
      bxi[k*IW +: IW] = IW'(k % C); byi[k*IW +: IW] = IW'((k + 1) % E); bzi[k*IW +: IW] = IW'(k % E);
    end
    step(1'b1, 1'b1, 1'b1);
    idle(4);

    // R8: same operation accumulates on top
    phase = "R8";
    step(1'b1, 1'b1, 1'b0);
    idle(4);

    // R5: no pre-add, Y has extreme values that must not matter
    phase = "R5";
    for (int e = 0; e < E; e++) by[e*DW +: DW] = 16'h7fff;
    step(1'b1, 1'b0, 1'b0);
    by = '1;
    step(1'b1, 1'b0, 1'b0);
    idle(4);

    // R6 / R11: random in-range indices, back to back
    phase = "R6";
    for (int i = 0; i < 40; i++) begin rand_ops(1'b1); step(1'b1, $urandom, 1'b0); end
    phase = "R11";
    for (int i = 0; i < 40; i++) begin rand_ops(1'b1); step(1'b1, $urandom, i % 9 == 0); end
    idle(4);

    // R7: out-of-range indices give zero operands
    phase = "R7";
    rand_ops(1'b1);
    bxi = '1; byi = '1;
    step(1'b1, 1'b1, 1'b0);
    rand_ops(1'b1);
    bzi = {N{4'd8}};
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 30; i++) begin rand_ops(1'b0); step(1'b1, $urandom, 1'b0); end
    idle(4);

    // R9: clear discards history
    phase = "R9";
    rand_ops(1'b1);
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    idle(4);

    // R10: maximum positive growth until 48-bit wrap
    phase = "R10";
    bx = {E{16'h8000}}; by = {E{16'h8000}}; bz = {E{16'h8000}};
    bxi = '0; byi = '0; bzi = '0;
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 16400; i++) step(1'b1, 1'b1, 1'b0);
    idle(5);
    n_chk++;
    if (exp_acc[0][AW-1] !== 1'b1 || acc_data[AW-1] !== 1'b1) begin
      n_fail++;
      $display("FAIL R10 wrap sign actual=%b expected=1", acc_data[AW-1]);
    end
    summary();
  end
endmodule